// File: doc/BRIEF.md
# Memory-Indirect Branch Target Fetcher

This block works out the destination of a jump or subroutine call whose target is held in memory. The instruction gives only an 8-bit pointer. The pointer is zero-extended into the lowest 256 bytes of the address space. The block reads the operand at that location over a 16-bit synchronous memory port and returns the branch target together with a one-cycle `done` pulse.

In normal (16-bit) addressing, one word is read and that word is the whole target. In advanced (24-bit) addressing, a 32-bit longword is read as two words: the upper half first, then the lower half. The top byte of the longword is discarded.

Memory is big-endian. The low address bit of the pointer is always cleared before the read. The low bit of the returned target is also always cleared.

Top module: `ind_branch_fetch`

## Requirements
- R1: After synchronous reset, `done` and `mem_req` are 0.
- R2: With `adv_mode`=0, exactly one read is issued, at byte address {aa8[7:1],0}. The target is {8'h00, word[15:1], 0}, where `word` is the `mem_rdata` value returned for that read.
- R3: With `adv_mode`=1, two reads are issued in order. The first is at the pointer address P and the second at P+2. The target is {first[7:0], second[15:1], 0}, and first[15:8] is ignored.
- R4: Every read address has bit 0 equal to 0, so an odd pointer reads from the preceding even address.
- R5: Bit 0 of `target` is 0 whenever `done` is 1, even if the fetched value is odd.
- R6: A `start` raised while a fetch is in progress is ignored. It causes no extra read and no extra `done`, and the running fetch returns its own target.
- R7: `done` is high for exactly one cycle per accepted fetch and is never high on two consecutive cycles.
- R8: Once `mem_req` is raised, it and `mem_addr` stay unchanged until a cycle in which `mem_ack` is 1. `mem_rdata` is taken in that cycle.
- R9: `mem_addr` bits 23:9 are always 0, because every read lies in bytes 0 to 257.
- R10: A `start` given in the same cycle as `done` is accepted as a new fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a fetch (accepted only when idle) |
| aa8 | input | 8 | Absolute pointer into bytes 0..255 |
| adv_mode | input | 1 | 1 = 24-bit advanced addressing, 0 = 16-bit normal addressing |
| mem_req | output | 1 | Read request |
| mem_addr | output | 24 | Read byte address |
| mem_rdata | input | 16 | Read data, valid when `mem_ack` is 1 |
| mem_ack | input | 1 | Read completes this cycle |
| target | output | 24 | Branch target, valid when `done` is 1 |
| done | output | 1 | One-cycle result strobe |

## Verification
Two functions can fall in the same cycle: completing a fetch, and accepting a new `start`.

The bench provokes this by raising `start` in the very cycle that `done` is high. The new fetch must go ahead, and its reads must match the scoreboard's expected address sequence.

The bench also raises `start` while a read is still waiting for its acknowledge. The scoreboard then fails the run if any extra address, or any extra or mismatched target, appears.

// File: rtl/ind_branch_fetch.sv
module ind_branch_fetch #(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PTR_W-1:0]  aa8,
  input  logic              adv_mode,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] target,
  output logic              done
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int RA_W  = PTR_W + 1;
  localparam int PAD_W = ADDR_W - RA_W;

  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2} st_t;

  st_t               st;
  logic [PTR_W-1:0]  ptr;
  logic              adv;
  logic [HI_W-1:0]   hi;
  logic [RA_W-1:0]   rd_addr;

  assign rd_addr  = (st == S_RD2) ? ({1'b0, ptr} + RA_W'(2)) : {1'b0, ptr};
  assign mem_addr = {{PAD_W{1'b0}}, rd_addr};
  assign mem_req  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ptr    <= '0;
      adv    <= 1'b0;
      hi     <= '0;
      target <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            ptr <= {aa8[PTR_W-1:1], 1'b0};
            adv <= adv_mode;
            st  <= S_RD1;
          end
        S_RD1:
          if (mem_ack) begin
            if (adv) begin
              hi <= mem_rdata[HI_W-1:0];
              st <= S_RD2;
            end else begin
              target <= {{HI_W{1'b0}}, mem_rdata[DATA_W-1:1], 1'b0};
              done   <= 1'b1;
              st     <= S_IDLE;
            end
          end
        S_RD2:
          if (mem_ack) begin
            target <= {hi, mem_rdata[DATA_W-1:1], 1'b0};
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ind_branch_fetch_chk #(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] target,
  input logic              done
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R4
  addr_even_chk: assert property (@(posedge clk) disable iff (rst) mem_req |-> !mem_addr[0]);
  // R9
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ADDR_W-1:PTR_W+1] == '0));
  // R5
  target_even_chk: assert property (@(posedge clk) disable iff (rst) done |-> !target[0]);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!done && !mem_req));
endmodule

bind ind_branch_fetch ind_branch_fetch_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .target(target), .done(done)
);

// File: tb/sim_ind_branch_fetch.sv
module sim_ind_branch_fetch;
  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [7:0]  aa8 = 0;
  logic        adv_mode = 0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata = 0;
  logic        mem_ack = 0;
  logic [23:0] target;
  logic        done;

  ind_branch_fetch u0 (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, lat = 0, wcnt = 0;
  logic [7:0] mem [0:511];
  int exp_addr_q[$];
  int exp_tgt_q[$];
  string exp_tag_q[$];
  logic prev_done = 0;
  bit finished = 0;

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model with configurable latency; also checks address order (R2, R3, R4)
  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 0;
    else if (mem_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        if (exp_addr_q.size() == 0) chk("R6 unexpected read", int'(mem_addr), -1);
        else chk("R3/R4 read address", int'(mem_addr), exp_addr_q.pop_front());
        mem_rdata <= {mem[mem_addr[8:0]], mem[mem_addr[8:0] + 9'd1]};
        mem_ack   <= 1;
      end else wcnt++;
    end
  end

  // monitor: pops expected targets on done (R2, R3, R5, R7)
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (prev_done) chk("R7 done twice", 1, 0);
        if (exp_tgt_q.size() == 0) chk("R6 extra done", int'(target), -1);
        else chk(exp_tag_q.pop_front(), int'(target), exp_tgt_q.pop_front());
      end
      prev_done = done;
    end
  end

  function automatic int w16(input int a);
    return {mem[a], mem[a+1]};
  endfunction

  task automatic issue(input int p, input bit adv, input string tag);
    int b = p & 'hFE;
    exp_addr_q.push_back(b);
    if (adv) begin
      exp_addr_q.push_back(b + 2);
      exp_tgt_q.push_back({mem[b+1], mem[b+2], mem[b+3] & 8'hFE});
    end else
      exp_tgt_q.push_back({8'h00, mem[b], mem[b+1] & 8'hFE});
    exp_tag_q.push_back(tag);
    start = 1; aa8 = p[7:0]; adv_mode = adv;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 done after reset", int'(done), 0);
    chk("R1 req after reset", int'(mem_req), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 req idle", int'(mem_req), 0);

    // R2 normal mode, even and odd pointer (R4), odd target (R5)
    mem[8'h40] = 8'h12; mem[8'h41] = 8'h35;
    issue('h40, 0, "R2 normal target"); wait_done();
    issue('h41, 0, "R4 odd pointer normal"); wait_done();
    mem[8'h10] = 8'hAB; mem[8'h11] = 8'hCD;
    issue('h10, 0, "R5 odd target normal"); wait_done();

    // R3 advanced mode, top byte ignored, top pointer 0xFF -> reads 0xFE and 0x100 (R9)
    mem[8'h20] = 8'hFF; mem[8'h21] = 8'h7A; mem[8'h22] = 8'h01; mem[8'h23] = 8'h03;
    issue('h20, 1, "R3 advanced target"); wait_done();
    lat = 2;
    issue('h23, 1, "R3 odd pointer advanced"); wait_done();
    issue('hFF, 1, "R9 top pointer advanced"); wait_done();
    issue('h00, 0, "R2 zero pointer"); wait_done();

    // R6 start during fetch ignored
    lat = 4;
    issue('h30, 1, "R6 first fetch kept");
    @(negedge clk);
    start = 1; aa8 = 8'h80; adv_mode = 0;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    start = 1; aa8 = 8'h90;
    @(negedge clk);
    start = 0;
    wait_done();
    repeat (6) @(negedge clk);
    chk("R6 idle after ignored start", int'(mem_req), 0);

    // R10 start in done cycle accepted
    lat = 0;
    issue('h50, 0, "R10 first"); wait_done();
    issue('h60, 1, "R10 back-to-back adv"); wait_done();
    issue('h71, 0, "R10 back-to-back normal"); wait_done();
    repeat (4) @(negedge clk);

    chk("R6 no pending reads", exp_addr_q.size(), 0);
    chk("R7 no pending targets", exp_tgt_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule